// File: doc/BRIEF.md
# Banked I/O Port Register Core

This block is the register heart of a 40-pin general-purpose I/O expander. The pins are arranged as five banks of eight. A small register bus sits in front of it, and a serial front end outside the block drives that bus. Each bus access names a bank, a register type and a data byte. A separate acknowledge strobe marks the end of each transferred byte.

Each bank keeps three registers. The direction register holds a 1 for an input and a 0 for an output. The output register sits behind a shadow byte. The polarity register flips input bits when they are read. Output bytes reach the pads only when the acknowledge strobe fires. An active-low output-enable input can float every pin set as an output, which allows external blinking or dimming of loads. Pad inputs pass through a two-flop synchronizer before they are read.

Top module: `gpio_bank_core`

## Requirements
- R1: Each of the 40 pins has its own direction bit. Pin `8*b+i` belongs to bank b, bit i. A direction bit of 1 makes the pin an input, with `pad_oe` low. A direction bit of 0 makes it an output, with `pad_oe` high while `oe_n` is low. A direction write takes effect in the cycle after the write.
- R2: Synchronous reset with `rst_n` low sets the state as follows. Every direction byte becomes 8'hFF. Output and polarity bytes become 8'h00. The synchronizer clears. So `pad_oe` and `pad_out` are all zero in the cycle after reset.
- R3: A write to the output register (`bus_sel` = 1) loads a shadow byte only. `pad_out` changes only in the cycle after a clock edge where `bus_ack` is high. At that edge every bank's shadow is copied to its live output. A write and an acknowledge in the same cycle send the new byte out at that edge.
- R4: While `oe_n` is high, `pad_oe` is all zero. Direction and output state are kept, and `pad_oe` returns when `oe_n` goes low again.
- R5: A read of the input register (`bus_sel` = 0) returns the synchronized pad byte XOR the bank's polarity byte.
- R6: Bank indices 5 to 7 read as 8'h00 for every register type, and writes to them change no state.
- R7: A change on `pad_in` first shows in an input read after the second rising clock edge.
- R8: Register select encoding: 0 input, 1 output, 2 polarity, 3 direction. Reads of polarity and direction return the stored byte.
- R9: A read of the output register returns the live byte driven on the pads, not a pending shadow byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_bank | input | 3 | Bank index |
| bus_sel | input | 2 | Register select (0 in, 1 out, 2 polarity, 3 direction) |
| bus_wdata | input | 8 | Write data byte |
| bus_ack | input | 1 | Byte acknowledge; commits shadow output bytes |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| oe_n | input | 1 | Active-low global output enable |
| pad_in | input | 40 | Pad input levels (asynchronous) |
| pad_out | output | 40 | Pad output values |
| pad_oe | output | 40 | Pad output enables, active high |

## Verification
The assertions check several rules on every cycle:
- `pad_out` holds still between acknowledges, and an acknowledged write lands on its bank.
- A high `oe_n` keeps every pad enable low.
- A direction write maps to the inverted enables of its bank.
- Out-of-range banks read zero, and the pins are all inputs just after reset.

Some behaviours can only be shown by the bench's scenarios:
- the two-edge latency of the synchronizer and the polarity XOR on reads;
- a read of the output register returning the live byte while a newer shadow byte is pending;
- writes to banks 5 to 7 leaving every pin untouched;
- a reset in mid-run returning all stored bytes to their defaults.

// File: rtl/gpio_bank_pkg.sv
// Shared types for the banked I/O register core.
// Assumes a two-bit register select on the bus.
package gpio_bank_pkg;

    // Register select encoding on the bus.
    typedef enum logic [1:0] {
        REG_IN  = 2'd0,
        REG_OUT = 2'd1,
        REG_POL = 2'd2,
        REG_DIR = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/gpio_sync.sv
// Multi-stage flop synchronizer for asynchronous pad inputs.
// Assumes STAGES >= 1; every stage clears on synchronous reset.
module gpio_sync #(
    parameter int W      = 40,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] stg;

    // Shift the pad sample through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            for (int s = STAGES - 1; s > 0; s--) begin
                stg[s] <= stg[s-1];
            end
            stg[0] <= din;
        end
    end

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/gpio_bank_regs.sv
// Register set for one bank: direction, polarity, shadow and live output.
// Assumes wr_en is already qualified by the bank decode.
// Every bank instance commits its shadow on ack.
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  reg_sel_e     sel,
    input  logic [W-1:0] wr_data,
    input  logic         ack,
    input  logic [W-1:0] in_sync,
    output logic [W-1:0] out_live,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] rd_data
);

    logic [W-1:0] shadow_q;
    logic [W-1:0] shadow_nxt;
    logic [W-1:0] pol_q;

    // Next shadow value, including a write in this cycle.
    always_comb begin
        shadow_nxt = shadow_q;
        if (wr_en && sel == REG_OUT) begin
            shadow_nxt = wr_data;
        end
    end

    // Shadow byte and acknowledge-timed live output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            out_live <= '0;
        end else begin
            shadow_q <= shadow_nxt;
            if (ack) begin
                out_live <= shadow_nxt;
            end
        end
    end

    // Direction and polarity bytes, written immediately.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '1;
            pol_q <= '0;
        end else if (wr_en) begin
            if (sel == REG_DIR) begin
                dir_q <= wr_data;
            end
            if (sel == REG_POL) begin
                pol_q <= wr_data;
            end
        end
    end

    // Read data for this bank by register type.
    always_comb begin
        unique case (sel)
            REG_IN:  rd_data = in_sync ^ pol_q;
            REG_OUT: rd_data = out_live;
            REG_POL: rd_data = pol_q;
            default: rd_data = dir_q;
        endcase
    end

endmodule

// File: rtl/gpio_rd_mux.sv
// Selects one bank's read byte.
// Indices at or above NB return zero.
module gpio_rd_mux #(
    parameter int NB    = 5,
    parameter int W     = 8,
    parameter int IDX_W = 3
) (
    input  logic [NB*W-1:0]  bank_rd,
    input  logic [IDX_W-1:0] idx,
    output logic [W-1:0]     rdata
);

    // Pick the addressed bank, or zero when out of range.
    always_comb begin
        rdata = '0;
        for (int b = 0; b < NB; b++) begin
            if (idx == IDX_W'(b)) begin
                rdata = bank_rd[b*W +: W];
            end
        end
    end

endmodule

// File: rtl/gpio_bank_core.sv
// Top of the banked I/O register core.
// It decodes bus writes per bank and builds the pad enables from the direction bits and oe_n.
// It returns read data through the read mux.
// Assumes oe_n is already clean, since it is used without synchronizing.
module gpio_bank_core
    import gpio_bank_pkg::*;
#(
    parameter int NUM_BANKS   = 5,
    parameter int BANK_W      = 8,
    parameter int IDX_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_we,
    input  logic [IDX_W-1:0]            bus_bank,
    input  logic [1:0]                  bus_sel,
    input  logic [BANK_W-1:0]           bus_wdata,
    input  logic                        bus_ack,
    output logic [BANK_W-1:0]           bus_rdata,
    input  logic                        oe_n,
    input  logic [NUM_BANKS*BANK_W-1:0] pad_in,
    output logic [NUM_BANKS*BANK_W-1:0] pad_out,
    output logic [NUM_BANKS*BANK_W-1:0] pad_oe
);

    localparam int PINS = NUM_BANKS * BANK_W;

    logic [PINS-1:0] in_sync;
    logic [PINS-1:0] dir_all;
    logic [PINS-1:0] rd_all;
    reg_sel_e        sel;

    assign sel = reg_sel_e'(bus_sel);

    gpio_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pad_in),
        .dout (in_sync)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = bus_we && (bus_bank == IDX_W'(b));

        gpio_bank_regs #(.W(BANK_W)) u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (hit),
            .sel     (sel),
            .wr_data (bus_wdata),
            .ack     (bus_ack),
            .in_sync (in_sync[b*BANK_W +: BANK_W]),
            .out_live(pad_out[b*BANK_W +: BANK_W]),
            .dir_q   (dir_all[b*BANK_W +: BANK_W]),
            .rd_data (rd_all[b*BANK_W +: BANK_W])
        );
    end

    // Drive only pins set as outputs, and only while the global enable is low.
    assign pad_oe = ~dir_all & {PINS{~oe_n}};

    gpio_rd_mux #(.NB(NUM_BANKS), .W(BANK_W), .IDX_W(IDX_W)) u_rd (
        .bank_rd(rd_all),
        .idx    (bus_bank),
        .rdata  (bus_rdata)
    );

endmodule

// File: rtl/gpio_bank_core_chk.sv
// Property checker for gpio_bank_core. It observes the ports only.
// It is attached to the top module by the bind statement below.
module gpio_bank_core_chk #(
    parameter int NUM_BANKS = 5,
    parameter int BANK_W    = 8,
    parameter int IDX_W     = 3
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        bus_we,
    input logic [IDX_W-1:0]            bus_bank,
    input logic [1:0]                  bus_sel,
    input logic [BANK_W-1:0]           bus_wdata,
    input logic                        bus_ack,
    input logic [BANK_W-1:0]           bus_rdata,
    input logic                        oe_n,
    input logic [NUM_BANKS*BANK_W-1:0] pad_in,
    input logic [NUM_BANKS*BANK_W-1:0] pad_out,
    input logic [NUM_BANKS*BANK_W-1:0] pad_oe
);

    // R2: the cycle after reset releases, all pins are undriven inputs with zero output.
    p_reset_inputs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0 && pad_out == '0));

    // R3: without an acknowledge, the pads keep their output value.
    p_hold_without_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ack |=> $stable(pad_out));

    // R4: a high global enable floats every pin.
    p_oe_float_r4: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> pad_oe == '0);

    // R6: out-of-range banks read zero.
    p_high_bank_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_bank >= IDX_W'(NUM_BANKS)) |-> bus_rdata == '0);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
        // R3: an acknowledged output write lands on its bank's pads.
        p_ack_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_ack && bus_sel == 2'd1 && bus_bank == IDX_W'(b))
            |=> pad_out[b*BANK_W +: BANK_W] == $past(bus_wdata));

        // R1: a direction write sets the inverted enables of its bank.
        p_dir_to_oe_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_sel == 2'd3 && bus_bank == IDX_W'(b))
            |=> (oe_n || pad_oe[b*BANK_W +: BANK_W] == ~$past(bus_wdata)));
    end

endmodule

bind gpio_bank_core gpio_bank_core_chk #(
    .NUM_BANKS(NUM_BANKS),
    .BANK_W   (BANK_W),
    .IDX_W    (IDX_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_bank (bus_bank),
    .bus_sel  (bus_sel),
    .bus_wdata(bus_wdata),
    .bus_ack  (bus_ack),
    .bus_rdata(bus_rdata),
    .oe_n     (oe_n),
    .pad_in   (pad_in),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe)
);

// File: tb/tb_gpio_bank_core.sv
// Self-checking bench for gpio_bank_core.
// A vector table comes first, then directed tests.
module tb_gpio_bank_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_bank = '0;
    logic [1:0]  bus_sel = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_ack = 1'b0;
    logic [7:0]  bus_rdata;
    logic        oe_n = 1'b0;
    logic [39:0] pad_in = '0;
    logic [39:0] pad_out;
    logic [39:0] pad_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    gpio_bank_core dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_bank(bus_bank),
        .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .oe_n(oe_n), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // Each vector is {bank[2:0], sel[1:0], write byte, expected read-back after ack}.
    localparam int NVEC = 8;
    localparam logic [20:0] VECS [NVEC] = '{
        {3'd0, 2'd3, 8'h0F, 8'h0F},
        {3'd4, 2'd3, 8'hF0, 8'hF0},
        {3'd2, 2'd1, 8'hA5, 8'hA5},
        {3'd4, 2'd2, 8'h3C, 8'h3C},
        {3'd6, 2'd3, 8'h00, 8'h00},
        {3'd5, 2'd1, 8'hFF, 8'h00},
        {3'd1, 2'd2, 8'hFF, 8'hFF},
        {3'd3, 2'd1, 8'h5A, 8'h5A}
    };

    task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] b, input logic [1:0] s, input logic [7:0] d, input logic a);
        @(negedge clk);
        bus_we = 1'b1; bus_bank = b; bus_sel = s; bus_wdata = d; bus_ack = a;
        @(negedge clk);
        bus_we = 1'b0; bus_ack = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk);
        bus_ack = 1'b1;
        @(negedge clk);
        bus_ack = 1'b0;
    endtask

    task automatic rd(input logic [2:0] b, input logic [1:0] s, input string tag, input logic [7:0] exp);
        bus_bank = b; bus_sel = s;
        #1;
        check(tag, {32'd0, bus_rdata}, {32'd0, exp});
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2: state right after reset
        check("R2 pad_oe after reset", pad_oe, 40'h0);
        check("R2 pad_out after reset", pad_out, 40'h0);
        for (int b = 0; b < 5; b++) rd(3'(b), 2'd3, "R2 direction reset", 8'hFF);
        rd(3'd0, 2'd2, "R2 polarity reset", 8'h00);

        // Vector table: write, acknowledge, read back (R8, R6)
        for (int i = 0; i < NVEC; i++) begin
            wr(VECS[i][20:18], VECS[i][17:16], VECS[i][15:8], 1'b0);
            pulse_ack();
            rd(VECS[i][20:18], VECS[i][17:16], "R8/R6 table readback", VECS[i][7:0]);
        end
        check("R3 pads after table acks", pad_out, 40'h00_5A_A5_00_00);

        // R1 and R6: pin enables follow direction; bank 5 write ignored
        wr(3'd5, 2'd3, 8'h00, 1'b0);
        check("R1/R6 pad_oe map", pad_oe, 40'h0F_00_00_00_F0);
        rd(3'd5, 2'd3, "R6 bank5 reads zero", 8'h00);

        // R3 and R9: a shadow write is held until ack; a read returns the live byte
        wr(3'd2, 2'd1, 8'h33, 1'b0);
        repeat (2) @(negedge clk);
        check("R3 held before ack", {32'd0, pad_out[23:16]}, 40'hA5);
        rd(3'd2, 2'd1, "R9 live read before ack", 8'hA5);
        pulse_ack();
        check("R3 after ack", {32'd0, pad_out[23:16]}, 40'h33);
        wr(3'd3, 2'd1, 8'h77, 1'b1);
        check("R3 write with ack same cycle", {32'd0, pad_out[31:24]}, 40'h77);

        // R4: the global enable floats outputs and then restores them
        @(negedge clk); oe_n = 1'b1;
        #1 check("R4 oe_n high floats", pad_oe, 40'h0);
        @(negedge clk);
        check("R4 outputs kept", pad_out, 40'h00_77_33_00_00);
        oe_n = 1'b0;
        #1 check("R4 enables return", pad_oe, 40'h0F_00_00_00_F0);

        // R7 and R5: two-edge latency, then polarity XOR
        @(negedge clk); pad_in[15:8] = 8'h0F; bus_bank = 3'd1; bus_sel = 2'd0;
        @(negedge clk);
        rd(3'd1, 2'd0, "R7 not yet after one edge", 8'hFF);
        @(negedge clk);
        rd(3'd1, 2'd0, "R5/R7 inverted after two edges", 8'hF0);
        wr(3'd1, 2'd2, 8'h00, 1'b0);
        rd(3'd1, 2'd0, "R5 no inversion", 8'h0F);

        // R2: reset in mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R2 mid-run pad_out", pad_out, 40'h0);
        check("R2 mid-run pad_oe", pad_oe, 40'h0);
        rd(3'd0, 2'd3, "R2 mid-run direction", 8'hFF);
        rd(3'd4, 2'd2, "R2 mid-run polarity", 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule